// File: doc/BRIEF.md
# Two-User OR-Channel Chip Code Codec

This block carries the bit streams of two users over one shared binary channel on which a chip reads 1 whenever either transmitter sends 1. Each user's encoder turns every accepted data bit, on its own, into a fixed block of chips. User A uses 4 chips per bit and user B uses 6 chips per bit, so twelve chips carry five data bits. A shared twelve-chip frame counter sets the block boundaries for both encoders and both receivers: three A blocks and two B blocks start at fixed chips of every frame, and the two streams are aligned at the frame start.

Each receiver watches the channel chips inside its own block window and decides the bit from the position of the first zero chip in that window. The A receiver asks whether the first zero lies in the early or the late half of its 4-chip window. The B receiver asks whether the first zero falls on an odd or an even position of its 6-chip window. The chip patterns are chosen so that, after the OR, every window holds a zero at a position that gives the correct decision for all four pairs of data bits. The block drives the ORed channel on `chan_out` and decodes whatever arrives on `chan_in`. In normal use the two are joined, either directly or through a channel model with no added delay.

Top module: `orc_pair_codec`

## Requirements
- R1: After reset, `a_in_ready` is high on one cycle in every 4 and `b_in_ready` on one cycle in every 6. Both are high together on the first cycle after reset and then every 12 cycles. A bit is taken when valid and ready are both high. A block whose ready cycle has valid low carries the code of data 0, and its receiver reports 0.
- R2: User A sends data 1 as chips 0,0,1,1 and data 0 as chips 1,1,0,0, with the first chip first.
- R3: User B sends data 1 as chips 0,1,0,1,0,1 and data 0 as chips 1,0,1,0,1,0, with the first chip first.
- R4: `chan_out` is the OR of both users' chips. Chip k of a block whose ready cycle is c appears on `chan_out` in cycle c+1+k.
- R5: For every combination of data, each 4-chip A window on `chan_out` holds at least one zero chip.
- R6: The A receiver outputs 1 when the first zero of its window on `chan_in` is at position 1 or 2, and outputs 0 when it is at position 3 or 4.
- R7: The B receiver outputs 1 when the first zero of its window on `chan_in` is at position 1, 3 or 5, and outputs 0 when it is at position 2, 4 or 6.
- R8: Receiver windows on `chan_in` use the same chip timing as R4. Each receiver raises its valid output for exactly one cycle, the cycle after the last chip of its window is on `chan_in`.
- R9: A window with no zero chip gives the valid pulse with the error output high and the bit output 0. The error output is low on every other cycle.
- R10: With `chan_out` fed back into `chan_in`, both receivers return every transmitted bit of both users in order, with the error output never high.
- R11: In the first cycle after reset, `chan_out` is 0, both valid outputs are 0 and both ready outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in_valid | input | 1 | User A data bit offered |
| a_in_data | input | 1 | User A data bit |
| a_in_ready | output | 1 | User A block starts this cycle |
| b_in_valid | input | 1 | User B data bit offered |
| b_in_data | input | 1 | User B data bit |
| b_in_ready | output | 1 | User B block starts this cycle |
| chan_out | output | 1 | OR of both users' chips |
| chan_in | input | 1 | Channel chip to decode |
| a_out_valid | output | 1 | User A decision pulse |
| a_out_bit | output | 1 | User A decoded bit |
| a_out_err | output | 1 | User A window held no zero |
| b_out_valid | output | 1 | User B decision pulse |
| b_out_bit | output | 1 | User B decoded bit |
| b_out_err | output | 1 | User B window held no zero |

## Verification
A frame counter that slips shifts the ready pulses and the window edges. The next decision pulse then lands off its expected cycle or decodes a bit against the wrong half, so the error shows within one 12-cycle frame. A stuck first-zero latch or a window state that is not cleared at the window edge shows in the next injected window whose first zero comes before a later zero of the other class, or in the next window that has no zero at all. A wrong chip table breaks the exact `chan_out` sequence of one frame and then, through the loopback, gives decoded bits that disagree with the sent data within a few blocks.

// File: rtl/orc_pkg.sv
package orc_pkg;

    localparam int LEN_A_DEF = 4;
    localparam int LEN_B_DEF = 6;

    // How a user's window is split into the two decision classes.
    typedef enum logic {
        RULE_HALF   = 1'b0,  // early half decides 1, late half decides 0
        RULE_PARITY = 1'b1   // odd positions (1-based) decide 1
    } rule_e;

    typedef struct packed {
        logic valid;
        logic bitv;
        logic err;
    } decision_t;

    // Least common multiple of two block lengths: the frame length.
    function automatic int frame_len(input int a, input int b);
        int r;
        r = a * b;
        for (int m = a * b; m >= 1; m--) begin
            if ((m % a == 0) && (m % b == 0)) r = m;
        end
        return r;
    endfunction

    // Chip value for data bit bitv at zero-based position pos of a block.
    function automatic logic code_chip(input rule_e rule, input logic bitv,
                                       input int pos, input int len);
        logic late;
        if (rule == RULE_HALF) late = (pos >= len / 2);
        else                   late = (pos % 2 == 1);
        return late ~^ bitv;
    endfunction

    // Decision for a first zero found at zero-based position pos.
    function automatic logic decide(input rule_e rule, input int pos, input int len);
        if (rule == RULE_HALF) return (pos < len / 2);
        return (pos % 2 == 0);
    endfunction

endpackage

// File: rtl/orc_frame_timer.sv
module orc_frame_timer
    import orc_pkg::*;
#(
    parameter int LEN_A = LEN_A_DEF,
    parameter int LEN_B = LEN_B_DEF,
    localparam int FRAME = frame_len(LEN_A, LEN_B),
    localparam int CW    = $clog2(FRAME),
    localparam int PAW   = $clog2(LEN_A),
    localparam int PBW   = $clog2(LEN_B)
) (
    input  logic           clk,
    input  logic           rst,
    output logic [PAW-1:0] pos_a,
    output logic [PBW-1:0] pos_b,
    output logic [PAW-1:0] pos_a_q,
    output logic [PBW-1:0] pos_b_q,
    output logic           live
);

    logic [CW-1:0] frame;

    assign pos_a = PAW'(int'(frame) % LEN_A);
    assign pos_b = PBW'(int'(frame) % LEN_B);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame   <= '0;
            pos_a_q <= '0;
            pos_b_q <= '0;
            live    <= 1'b0;
        end else begin
            frame   <= (frame == CW'(FRAME - 1)) ? '0 : frame + 1'b1;
            pos_a_q <= pos_a;
            pos_b_q <= pos_b;
            live    <= 1'b1;
        end
    end

endmodule

// File: rtl/orc_chip_encoder.sv
module orc_chip_encoder
    import orc_pkg::*;
#(
    parameter int    LEN  = LEN_A_DEF,
    parameter rule_e RULE = RULE_HALF,
    localparam int   PW   = $clog2(LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] pos,
    input  logic          in_valid,
    input  logic          in_data,
    output logic          in_ready,
    output logic          chip
);

    logic held;
    logic cur_bit;

    assign in_ready = (pos == '0);
    assign cur_bit  = in_ready ? (in_valid & in_data) : held;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b0;
            chip <= 1'b0;
        end else begin
            held <= cur_bit;
            chip <= code_chip(RULE, cur_bit, int'(pos), LEN);
        end
    end

endmodule

// File: rtl/orc_zero_decoder.sv
module orc_zero_decoder
    import orc_pkg::*;
#(
    parameter int    LEN  = LEN_A_DEF,
    parameter rule_e RULE = RULE_HALF,
    localparam int   PW   = $clog2(LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          live,
    input  logic [PW-1:0] pos,
    input  logic          chip,
    output decision_t     dec
);

    logic          found;
    logic [PW-1:0] first_pos;
    logic          hit;
    logic          cur_found;
    logic [PW-1:0] cur_pos;
    logic          last;

    assign hit       = live & ~chip & ~found;
    assign cur_found = found | hit;
    assign cur_pos   = found ? first_pos : pos;
    assign last      = live && (pos == PW'(LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            found     <= 1'b0;
            first_pos <= '0;
            dec       <= '0;
        end else begin
            dec.valid <= last;
            dec.bitv  <= last && cur_found && decide(RULE, int'(cur_pos), LEN);
            dec.err   <= last && !cur_found;
            if (last) begin
                found <= 1'b0;
            end else if (hit) begin
                found     <= 1'b1;
                first_pos <= pos;
            end
        end
    end

endmodule

// File: rtl/orc_pair_codec.sv
module orc_pair_codec
    import orc_pkg::*;
#(
    parameter int LEN_A = LEN_A_DEF,
    parameter int LEN_B = LEN_B_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic a_in_valid,
    input  logic a_in_data,
    output logic a_in_ready,
    input  logic b_in_valid,
    input  logic b_in_data,
    output logic b_in_ready,
    output logic chan_out,
    input  logic chan_in,
    output logic a_out_valid,
    output logic a_out_bit,
    output logic a_out_err,
    output logic b_out_valid,
    output logic b_out_bit,
    output logic b_out_err
);

    localparam int PAW = $clog2(LEN_A);
    localparam int PBW = $clog2(LEN_B);

    logic [PAW-1:0] pos_a, pos_a_q;
    logic [PBW-1:0] pos_b, pos_b_q;
    logic           live;
    logic           chip_a, chip_b;
    decision_t      dec_a, dec_b;

    orc_frame_timer #(.LEN_A(LEN_A), .LEN_B(LEN_B)) u_timer (
        .clk(clk), .rst(rst),
        .pos_a(pos_a), .pos_b(pos_b),
        .pos_a_q(pos_a_q), .pos_b_q(pos_b_q),
        .live(live)
    );

    orc_chip_encoder #(.LEN(LEN_A), .RULE(RULE_HALF)) u_enc_a (
        .clk(clk), .rst(rst), .pos(pos_a),
        .in_valid(a_in_valid), .in_data(a_in_data),
        .in_ready(a_in_ready), .chip(chip_a)
    );

    orc_chip_encoder #(.LEN(LEN_B), .RULE(RULE_PARITY)) u_enc_b (
        .clk(clk), .rst(rst), .pos(pos_b),
        .in_valid(b_in_valid), .in_data(b_in_data),
        .in_ready(b_in_ready), .chip(chip_b)
    );

    assign chan_out = chip_a | chip_b;

    orc_zero_decoder #(.LEN(LEN_A), .RULE(RULE_HALF)) u_dec_a (
        .clk(clk), .rst(rst), .live(live), .pos(pos_a_q),
        .chip(chan_in), .dec(dec_a)
    );

    orc_zero_decoder #(.LEN(LEN_B), .RULE(RULE_PARITY)) u_dec_b (
        .clk(clk), .rst(rst), .live(live), .pos(pos_b_q),
        .chip(chan_in), .dec(dec_b)
    );

    assign a_out_valid = dec_a.valid;
    assign a_out_bit   = dec_a.bitv;
    assign a_out_err   = dec_a.err;
    assign b_out_valid = dec_b.valid;
    assign b_out_bit   = dec_b.bitv;
    assign b_out_err   = dec_b.err;

endmodule

// File: rtl/orc_pair_codec_chk.sv
module orc_pair_codec_chk #(
    parameter int LEN_A = 4,
    parameter int LEN_B = 6,
    localparam int PAW = $clog2(LEN_A),
    localparam int PBW = $clog2(LEN_B)
) (
    input logic           clk,
    input logic           rst,
    input logic           a_in_ready,
    input logic           b_in_ready,
    input logic           chan_out,
    input logic           a_out_valid,
    input logic           a_out_bit,
    input logic           a_out_err,
    input logic           b_out_valid,
    input logic           b_out_bit,
    input logic           b_out_err,
    input logic [PAW-1:0] pos_a_q,
    input logic [PBW-1:0] pos_b_q,
    input logic           live
);

    logic zero_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            zero_seen <= 1'b0;
        end else if (live) begin
            if (pos_a_q == PAW'(LEN_A - 1)) zero_seen <= 1'b0;
            else                            zero_seen <= zero_seen | ~chan_out;
        end
    end

    // R1: a ready pulse lasts one cycle
    assert_ready_a_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        a_in_ready |=> !a_in_ready);
    assert_ready_b_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        b_in_ready |=> !b_in_ready);

    // R5: every A window on the channel holds a zero chip
    assert_zero_present_R5: assert property (@(posedge clk) disable iff (rst)
        (live && pos_a_q == PAW'(LEN_A - 1)) |-> (zero_seen || !chan_out));

    // R8: decision pulse follows the last chip of the window, one cycle long
    assert_strobe_a_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        (live && pos_a_q == PAW'(LEN_A - 1)) |=> a_out_valid);
    assert_strobe_b_after_last_R8: assert property (@(posedge clk) disable iff (rst)
        (live && pos_b_q == PBW'(LEN_B - 1)) |=> b_out_valid);
    assert_strobe_a_single_R8: assert property (@(posedge clk) disable iff (rst)
        a_out_valid |=> !a_out_valid);
    assert_strobe_b_single_R8: assert property (@(posedge clk) disable iff (rst)
        b_out_valid |=> !b_out_valid);

    // R9: error only with the pulse, and then the bit is 0
    assert_err_a_R9: assert property (@(posedge clk) disable iff (rst)
        a_out_err |-> (a_out_valid && !a_out_bit));
    assert_err_b_R9: assert property (@(posedge clk) disable iff (rst)
        b_out_err |-> (b_out_valid && !b_out_bit));

endmodule

bind orc_pair_codec orc_pair_codec_chk #(.LEN_A(LEN_A), .LEN_B(LEN_B)) u_chk (
    .clk(clk), .rst(rst),
    .a_in_ready(a_in_ready), .b_in_ready(b_in_ready),
    .chan_out(chan_out),
    .a_out_valid(a_out_valid), .a_out_bit(a_out_bit), .a_out_err(a_out_err),
    .b_out_valid(b_out_valid), .b_out_bit(b_out_bit), .b_out_err(b_out_err),
    .pos_a_q(pos_a_q), .pos_b_q(pos_b_q), .live(live)
);

// File: tb/orc_pair_codec_tb.sv
module orc_pair_codec_tb;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_in_valid = 1'b0, a_in_data = 1'b0, a_in_ready;
    logic b_in_valid = 1'b0, b_in_data = 1'b0, b_in_ready;
    logic chan_out, chan_in;
    logic a_out_valid, a_out_bit, a_out_err;
    logic b_out_valid, b_out_bit, b_out_err;
    logic inj_en = 1'b0, inj_bit = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    string cur_req = "R10";

    int inj_lo = -1, inj_hi = -1;
    bit exp_a[$];
    bit exp_b[$];
    bit ia_bit[$], ia_err[$], ib_bit[$], ib_err[$];
    int ia_cyc[$], ib_cyc[$];

    assign chan_in = inj_en ? inj_bit : chan_out;

    orc_pair_codec u_dut (
        .clk(clk), .rst(rst),
        .a_in_valid(a_in_valid), .a_in_data(a_in_data), .a_in_ready(a_in_ready),
        .b_in_valid(b_in_valid), .b_in_data(b_in_data), .b_in_ready(b_in_ready),
        .chan_out(chan_out), .chan_in(chan_in),
        .a_out_valid(a_out_valid), .a_out_bit(a_out_bit), .a_out_err(a_out_err),
        .b_out_valid(b_out_valid), .b_out_bit(b_out_bit), .b_out_err(b_out_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Model of the block order: one expected bit per block, decided at ready.
    always @(negedge clk) begin
        if (!rst) begin
            if (a_in_ready) exp_a.push_back(a_in_valid && a_in_data);
            if (b_in_ready) exp_b.push_back(b_in_valid && b_in_data);
            if (a_out_valid) begin
                bit e;
                e = (exp_a.size() > 0) ? exp_a.pop_front() : 1'b0;
                if (cyc >= inj_lo && cyc <= inj_hi) begin
                    ia_bit.push_back(a_out_bit);
                    ia_err.push_back(a_out_err);
                    ia_cyc.push_back(cyc);
                end else begin
                    check(cur_req, "user A decoded bit", int'(a_out_bit), int'(e));
                    check(cur_req, "user A error flag", int'(a_out_err), 0);
                end
            end
            if (b_out_valid) begin
                bit e;
                e = (exp_b.size() > 0) ? exp_b.pop_front() : 1'b0;
                if (cyc >= inj_lo && cyc <= inj_hi) begin
                    ib_bit.push_back(b_out_bit);
                    ib_err.push_back(b_out_err);
                    ib_cyc.push_back(cyc);
                end else begin
                    check(cur_req, "user B decoded bit", int'(b_out_bit), int'(e));
                    check(cur_req, "user B error flag", int'(b_out_err), 0);
                end
            end
        end
    end

    function automatic logic pat_a(input logic b, input int k);
        return b ? (k >= 2) : (k < 2);
    endfunction

    function automatic logic pat_b(input logic b, input int k);
        return b ? (k % 2 == 1) : (k % 2 == 0);
    endfunction

    task automatic wait_frame_start(output int f);
        do @(negedge clk); while (!(a_in_ready && b_in_ready));
        f = cyc;
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R11", "chan_out after reset", int'(chan_out), 0);
        check("R11", "A valid after reset", int'(a_out_valid), 0);
        check("R11", "B valid after reset", int'(b_out_valid), 0);
        check("R11", "A ready first cycle", int'(a_in_ready), 1);
        check("R11", "B ready first cycle", int'(b_in_ready), 1);
    endtask

    task automatic test_ready_period();
        int f, na, nb, nboth;
        wait_frame_start(f);
        na = 0; nb = 0; nboth = 0;
        for (int t = 0; t < 24; t++) begin
            if (t > 0) @(negedge clk);
            if (a_in_ready) na++;
            if (b_in_ready) nb++;
            if (a_in_ready && b_in_ready) nboth++;
            if (t == 4) check("R1", "A ready at chip 4", int'(a_in_ready), 1);
            if (t == 6) check("R1", "B ready at chip 6", int'(b_in_ready), 1);
        end
        check("R1", "A ready count in 24 cycles", na, 6);
        check("R1", "B ready count in 24 cycles", nb, 4);
        check("R1", "joint ready count in 24 cycles", nboth, 2);
    endtask

    task automatic test_chip_patterns(input logic [2:0] abits, input logic [1:0] bbits);
        int f;
        logic e;
        cur_req = "R10";
        wait_frame_start(f);
        repeat (12) @(posedge clk);
        for (int t = 0; t <= 12; t++) begin
            if (t > 0) @(posedge clk);
            #1;
            a_in_valid = 1'b1;
            b_in_valid = 1'b1;
            if (t % 4 == 0 && t < 12) a_in_data = abits[t / 4];
            if (t % 6 == 0 && t < 12) b_in_data = bbits[t / 6];
            @(negedge clk);
            if (t >= 1) begin
                e = pat_a(abits[(t - 1) / 4], (t - 1) % 4) |
                    pat_b(bbits[(t - 1) / 6], (t - 1) % 6);
                check("R4", $sformatf("chan_out chip %0d (R2 R3)", t - 1),
                      int'(chan_out), int'(e));
            end
        end
        a_in_valid = 1'b0;
        b_in_valid = 1'b0;
    endtask

    task automatic test_random(input int ncyc);
        cur_req = "R10";
        for (int i = 0; i < ncyc; i++) begin
            @(posedge clk);
            #1;
            a_in_valid = ($urandom % 5) != 0;
            b_in_valid = ($urandom % 5) != 0;
            a_in_data  = $urandom % 2;
            b_in_data  = $urandom % 2;
        end
        a_in_valid = 1'b0;
        b_in_valid = 1'b0;
        repeat (20) @(posedge clk);
    endtask

    task automatic test_idle();
        cur_req = "R1";
        @(posedge clk);
        #1;
        a_in_valid = 1'b0;
        b_in_valid = 1'b0;
        a_in_data  = 1'b1;
        b_in_data  = 1'b1;
        repeat (40) @(posedge clk);
        #1;
        a_in_data = 1'b0;
        b_in_data = 1'b0;
        cur_req = "R10";
    endtask

    task automatic test_inject(input string name, input logic [0:11] vec,
                               input logic [2:0] ea_bit, input logic [2:0] ea_err,
                               input logic [1:0] eb_bit, input logic [1:0] eb_err);
        int f;
        wait_frame_start(f);
        inj_lo = f + 5;
        inj_hi = f + 13;
        ia_bit.delete(); ia_err.delete(); ia_cyc.delete();
        ib_bit.delete(); ib_err.delete(); ib_cyc.delete();
        for (int k = 0; k < 12; k++) begin
            @(posedge clk);
            #1;
            inj_en  = 1'b1;
            inj_bit = vec[k];
        end
        @(posedge clk);
        #1;
        inj_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        #1;
        check("R8", {name, " A decision count"}, ia_bit.size(), 3);
        check("R8", {name, " B decision count"}, ib_bit.size(), 2);
        if (ia_bit.size() == 3) begin
            for (int w = 0; w < 3; w++) begin
                check("R6", $sformatf("%s A window %0d bit", name, w),
                      int'(ia_bit[w]), int'(ea_bit[w]));
                check("R9", $sformatf("%s A window %0d err", name, w),
                      int'(ia_err[w]), int'(ea_err[w]));
                check("R8", $sformatf("%s A window %0d pulse cycle", name, w),
                      ia_cyc[w], f + 5 + 4 * w);
            end
        end
        if (ib_bit.size() == 2) begin
            for (int w = 0; w < 2; w++) begin
                check("R7", $sformatf("%s B window %0d bit", name, w),
                      int'(ib_bit[w]), int'(eb_bit[w]));
                check("R9", $sformatf("%s B window %0d err", name, w),
                      int'(ib_err[w]), int'(eb_err[w]));
                check("R8", $sformatf("%s B window %0d pulse cycle", name, w),
                      ib_cyc[w], f + 7 + 6 * w);
            end
        end
        inj_lo = -1;
        inj_hi = -1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        test_reset();
        test_ready_period();
        test_chip_patterns(3'b101, 2'b10);
        test_chip_patterns(3'b010, 2'b01);
        test_chip_patterns(3'b111, 2'b00);
        test_random(600);
        test_idle();
        // window bits listed with window 0 at bit 0
        test_inject("v1", 12'b1011_1110_0100, 3'b101, 3'b000, 2'b00, 2'b00);
        test_inject("v2", 12'b1111_1111_1111, 3'b000, 3'b111, 2'b00, 2'b11);
        test_inject("v3", 12'b1101_1111_1101, 3'b000, 3'b010, 2'b11, 2'b00);
        test_inject("v4", 12'b1111_1001_1111, 3'b010, 3'b101, 2'b10, 2'b00);
        test_random(300);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule